// File: doc/BRIEF.md
# Mu-law Codec Register Unit

This block is a byte-wide register slave that converts audio samples between 16-bit two's-complement linear form and 8-bit mu-law codes. Software reaches it through a small address window that holds a configuration register and a pair of data registers, low byte and high byte. The same pair is used for the operand and for the result, so each conversion overwrites its own input in place.

With the serial audio port switched off, software uses the block as a stand-alone converter. It picks a mode and then writes to the data-high register, which starts a conversion that completes one cycle later. With the port switched on, the converter moves into the sample streams. A byte written to data-high leaves on the transmit side as a linear sample. A sample that arrives on the receive side is stored in the data registers, compressed or raw. The serial shifter itself is not part of the block. Simple valid/ready ports stand in for it.

Top module: `mulaw_codec_regs`

## Requirements
- R1: After synchronous reset, the configuration register, both data registers, `busy` and `tx_valid` are all zero, which leaves the serial port disabled.
- R2: The address map is: 0 = configuration (bit 0 port enable, bit 1 expand mode, bit 2 compress mode), 2 = data-low, 3 = data-high. Addresses 1 and 4 to 8 read as zero and ignore writes. `bus_rdata` shows the register selected by `bus_addr` one cycle later.
- R3: Stand-alone expansion applies when enable = 0, expand = 1 and compress = 0. A write to data-high raises `busy` on the next cycle. After that cycle, data-high:data-low hold the 16-bit expansion of the written byte.
- R4: Stand-alone compression applies when enable = 0, compress = 1 and expand = 0. A write to data-high converts {written byte, data-low as held before}. After the busy cycle, data-high holds the 8-bit code and data-low keeps its value.
- R5: `busy` stays high for exactly one cycle. A read issued in that cycle returns the register contents from before the triggering write. Writes to data-low or data-high during that cycle are dropped.
- R6: With enable = 0, when both mode bits are set or both are clear, a write to data-high only stores the byte and `busy` stays low.
- R7: Compression works as follows. Take the sign bit. Clip the magnitude to 32635 and add 132. The segment is the index of the top set bit minus 7. The mantissa is the 4 bits just below that top bit. The code is the bit inverse of {sign, segment[2:0], mantissa[3:0]}.
- R8: Expansion inverts the code. It then forms ((mantissa*8 + 132) << segment) - 132 and negates the result when the sign bit is set.
- R9: With enable = 1, a write to data-high stores the byte and loads the transmit slot on the next cycle. The slot receives the expansion of the byte when expand = 1, and {byte, data-low} otherwise. `busy` never rises.
- R10: `tx_valid` with `tx_sample` holds steady until a cycle with `tx_ready` high. It then drops on the next cycle, unless a new load arrives in that same cycle.
- R11: With enable = 1, `rx_valid` loads the data registers on the next cycle. When compress = 1, data-high receives the code of `rx_sample`. Otherwise data-high:data-low receive the raw sample. A receive beat takes precedence over a bus write to a data register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| busy | output | 1 | Stand-alone conversion in progress |
| rx_valid | input | 1 | Received sample present |
| rx_sample | input | 16 | Received linear sample |
| tx_valid | output | 1 | Transmit slot holds a sample |
| tx_sample | output | 16 | Transmit sample |
| tx_ready | input | 1 | Transmit side accepts the sample |

## Verification
The bench drives the clip points 32767 and -32768, zero, minus one, and the two codes for signed zero. A design that gets the clip, the bias or the inversion wrong returns a code that is one segment off or that has the wrong sign. All 256 codes are expanded against an independent formula, which exposes any fault in the segment shift. A read during the busy cycle and a data write dropped during that cycle catch a design that exposes the operand or lets a stray write corrupt the result. Setting both mode bits checks that no conversion starts. A receive beat that collides with a bus write, and a transmit sample held while ready is low, cover the ordering of the streaming paths.

// File: rtl/mulaw_pkg.sv
package mulaw_pkg;
  localparam int CODE_W = 8;
  localparam int LIN_W  = 16;

  localparam int ADR_CFG0 = 0;
  localparam int ADR_DLO  = 2;
  localparam int ADR_DHI  = 3;

  localparam int CFG_EN  = 0;
  localparam int CFG_EXP = 1;
  localparam int CFG_CMP = 2;
  localparam int CFG_W   = 3;

  typedef enum logic {
    OP_EXPAND   = 1'b0,
    OP_COMPRESS = 1'b1
  } conv_op_e;
endpackage

// File: rtl/mulaw_enc.sv
module mulaw_enc import mulaw_pkg::*; #(
  parameter int CLIP = 32635,
  parameter int BIAS = 132
) (
  input  logic [LIN_W-1:0]  lin,
  output logic [CODE_W-1:0] code
);
  localparam int MAG_W    = LIN_W + 1;
  localparam int SEG_BASE = 7;
  localparam int SEGS     = 8;
  localparam logic [MAG_W-1:0] CLIP_V = MAG_W'(CLIP);
  localparam logic [MAG_W-1:0] BIAS_V = MAG_W'(BIAS);

  logic             sgn;
  logic [MAG_W-1:0] mag_raw, mag_clip, biased;
  logic [2:0]       seg;
  logic [3:0]       mant;

  always_comb begin
    sgn      = lin[LIN_W-1];
    mag_raw  = sgn ? ({1'b0, ~lin} + MAG_W'(1)) : {1'b0, lin};
    mag_clip = (mag_raw > CLIP_V) ? CLIP_V : mag_raw;
    biased   = mag_clip + BIAS_V;
    seg      = 3'd0;
    for (int i = 1; i < SEGS; i++) begin
      if (biased[SEG_BASE + i]) seg = 3'(i);
    end
    mant = 4'(biased >> (5'(seg) + 5'd3));
    code = ~{sgn, seg, mant};
  end
endmodule

// File: rtl/mulaw_dec.sv
module mulaw_dec import mulaw_pkg::*; #(
  parameter int BIAS = 132
) (
  input  logic [CODE_W-1:0] code,
  output logic [LIN_W-1:0]  lin
);
  localparam logic [LIN_W-1:0] BIAS_V = LIN_W'(BIAS);

  logic [CODE_W-1:0] inv;
  logic [LIN_W-1:0]  step, scaled, mag;

  always_comb begin
    inv    = ~code;
    step   = (LIN_W'(inv[3:0]) << 3) + BIAS_V;
    scaled = step << inv[6:4];
    mag    = scaled - BIAS_V;
    lin    = inv[7] ? (~mag + LIN_W'(1)) : mag;
  end
endmodule

// File: rtl/mulaw_tx_hold.sv
module mulaw_tx_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mulaw_codec_regs.sv
module mulaw_codec_regs import mulaw_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int CLIP   = 32635,
  parameter int BIAS   = 132
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CODE_W-1:0]   bus_wdata,
  output logic [CODE_W-1:0]   bus_rdata,
  output logic                busy,
  input  logic                rx_valid,
  input  logic [LIN_W-1:0]    rx_sample,
  output logic                tx_valid,
  output logic [LIN_W-1:0]    tx_sample,
  input  logic                tx_ready
);
  logic [CFG_W-1:0]  cfg_q;
  logic [CODE_W-1:0] dat_lo_q, dat_hi_q;
  logic [LIN_W-1:0]  pend_q;
  conv_op_e          op_q;
  logic              busy_q;

  logic cfg_en, mode_exp, mode_cmp;
  logic wr_cfg, wr_lo, wr_hi, rx_take, start_exp, start_cmp, tx_load;
  logic [LIN_W-1:0]  enc_in, dec_out, tx_data;
  logic [CODE_W-1:0] dec_in, enc_out;

  assign cfg_en   = cfg_q[CFG_EN];
  assign mode_exp = cfg_q[CFG_EXP];
  assign mode_cmp = cfg_q[CFG_CMP];

  assign wr_cfg    = bus_wr && (bus_addr == ADDR_W'(ADR_CFG0));
  assign wr_lo     = bus_wr && (bus_addr == ADDR_W'(ADR_DLO)) && !busy_q;
  assign wr_hi     = bus_wr && (bus_addr == ADDR_W'(ADR_DHI)) && !busy_q;
  assign rx_take   = cfg_en && rx_valid && !busy_q;
  assign start_exp = wr_hi && !cfg_en && mode_exp && !mode_cmp;
  assign start_cmp = wr_hi && !cfg_en && mode_cmp && !mode_exp;
  assign tx_load   = wr_hi && cfg_en;

  assign enc_in  = busy_q ? pend_q : rx_sample;
  assign dec_in  = busy_q ? pend_q[CODE_W-1:0] : bus_wdata;
  assign tx_data = mode_exp ? dec_out : {bus_wdata, dat_lo_q};

  mulaw_enc #(.CLIP(CLIP), .BIAS(BIAS)) u_enc (.lin(enc_in), .code(enc_out));
  mulaw_dec #(.BIAS(BIAS)) u_dec (.code(dec_in), .lin(dec_out));

  mulaw_tx_hold #(.W(LIN_W)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .load_data(tx_data),
    .ready(tx_ready), .valid(tx_valid), .data(tx_sample)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      dat_lo_q  <= '0;
      dat_hi_q  <= '0;
      pend_q    <= '0;
      op_q      <= OP_EXPAND;
      busy_q    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      busy_q <= start_exp || start_cmp;
      if (wr_cfg) cfg_q <= bus_wdata[CFG_W-1:0];

      if (start_exp) begin
        op_q   <= OP_EXPAND;
        pend_q <= {{(LIN_W-CODE_W){1'b0}}, bus_wdata};
      end else if (start_cmp) begin
        op_q   <= OP_COMPRESS;
        pend_q <= {bus_wdata, dat_lo_q};
      end

      if (busy_q) begin
        if (op_q == OP_EXPAND) {dat_hi_q, dat_lo_q} <= dec_out;
        else                   dat_hi_q <= enc_out;
      end else if (rx_take) begin
        if (mode_cmp) dat_hi_q <= enc_out;
        else          {dat_hi_q, dat_lo_q} <= rx_sample;
      end else begin
        if (wr_lo) dat_lo_q <= bus_wdata;
        if (wr_hi && !start_exp && !start_cmp) dat_hi_q <= bus_wdata;
      end

      case (bus_addr)
        ADDR_W'(ADR_CFG0): bus_rdata <= {{(CODE_W-CFG_W){1'b0}}, cfg_q};
        ADDR_W'(ADR_DLO):  bus_rdata <= dat_lo_q;
        ADDR_W'(ADR_DHI):  bus_rdata <= dat_hi_q;
        default:           bus_rdata <= '0;
      endcase
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/mulaw_codec_regs_chk.sv
module mulaw_codec_regs_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              busy,
  input logic              tx_valid,
  input logic [15:0]       tx_sample,
  input logic              tx_ready,
  input logic              cfg_en
);
  logic hi_write;
  assign hi_write = bus_wr && (bus_addr == ADDR_W'(3));

  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!busy && !tx_valid)); // R1
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (rst) busy |=> !busy); // R5
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(hi_write)); // R3
  AST_BUSY_NOT_STREAM: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !$past(cfg_en)); // R9
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !hi_write) |=> (tx_valid && $stable(tx_sample))); // R10
  AST_TX_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !hi_write) |=> !tx_valid); // R10
endmodule

bind mulaw_codec_regs mulaw_codec_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .busy(busy),
  .tx_valid(tx_valid), .tx_sample(tx_sample), .tx_ready(tx_ready), .cfg_en(cfg_en)
);

// File: tb/mulaw_codec_regs_bench.sv
module mulaw_codec_regs_bench;
  localparam int PERIOD = 10;
  localparam int NV = 5;
  // {linear sample, expected code}
  localparam logic [23:0] CMP_VEC [NV] = '{
    24'h0000_FF, 24'h7FFF_80, 24'h8000_00, 24'h03E8_CE, 24'hFFFF_7F };
  // {code, expected linear sample}
  localparam logic [23:0] EXP_VEC [NV] = '{
    24'hFF_0000, 24'h7F_0000, 24'h80_7D7C, 24'h00_8284, 24'hCE_03DC };

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        busy, rx_valid = 1'b0, tx_valid, tx_ready = 1'b0;
  logic [15:0] rx_sample = '0, tx_sample;
  int n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  mulaw_codec_regs u_mulaw_codec_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .rx_valid(rx_valid), .rx_sample(rx_sample),
    .tx_valid(tx_valid), .tx_sample(tx_sample), .tx_ready(tx_ready)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  function automatic logic [15:0] ref_expand(input logic [7:0] code);
    logic [7:0] c;
    int m, e, mag;
    c = ~code;
    e = int'(c[6:4]);
    m = int'(c[3:0]);
    mag = ((2*m + 33) << (e + 2)) - 132;
    return c[7] ? 16'(-mag) : 16'(mag);
  endfunction

  initial begin
    #(PERIOD*200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, lo_v;
    logic [7:0] prev_hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 tx_valid", {15'd0, tx_valid}, 16'd0);
    rd(4'd0, v); chk("R1 cfg0", {8'd0, v}, 16'd0);
    rd(4'd2, v); chk("R1 dlo", {8'd0, v}, 16'd0);
    rd(4'd3, v); chk("R1 dhi", {8'd0, v}, 16'd0);

    // R2 unused addresses read zero
    wr(4'd5, 8'hA5); rd(4'd5, v); chk("R2 addr5", {8'd0, v}, 16'd0);
    wr(4'd1, 8'h3C); rd(4'd1, v); chk("R2 addr1", {8'd0, v}, 16'd0);

    // R4 / R7 compression vectors, R5 read during busy
    prev_hi = 8'h00;
    wr(4'd0, 8'h04);
    for (int i = 0; i < NV; i++) begin
      wr(4'd2, CMP_VEC[i][15:8]);
      wr(4'd3, CMP_VEC[i][23:16]);
      chk("R5 busy raised", {15'd0, busy}, 16'd1);
      rd(4'd3, v); chk("R5 read during busy", {8'd0, v}, {8'd0, prev_hi});
      chk("R5 busy one cycle", {15'd0, busy}, 16'd0);
      rd(4'd3, v); chk("R7 code", {8'd0, v}, {8'd0, CMP_VEC[i][7:0]});
      rd(4'd2, v); chk("R4 low kept", {8'd0, v}, {8'd0, CMP_VEC[i][15:8]});
      prev_hi = CMP_VEC[i][7:0];
    end

    // R3 / R8 expansion vectors
    wr(4'd0, 8'h02);
    for (int i = 0; i < NV; i++) begin
      wr(4'd3, EXP_VEC[i][23:16]);
      chk("R3 busy raised", {15'd0, busy}, 16'd1);
      rd(4'd3, v); chk("R5 read during busy", {8'd0, v}, {8'd0, prev_hi});
      rd(4'd3, v); rd(4'd2, lo_v);
      chk("R8 expand", {v, lo_v}, EXP_VEC[i][15:0]);
      prev_hi = EXP_VEC[i][15:8];
    end

    // R8 full sweep of codes against reference formula
    for (int c = 0; c < 256; c++) begin
      wr(4'd3, 8'(c));
      @(negedge clk);
      rd(4'd3, v); rd(4'd2, lo_v);
      chk("R8 sweep", {v, lo_v}, ref_expand(8'(c)));
    end

    // R5 data write during busy is dropped
    wr(4'd3, 8'hCE);
    wr(4'd2, 8'h12);
    rd(4'd2, v); chk("R5 write in busy dropped", {8'd0, v}, 16'h00DC);

    // R6 both mode bits / no mode bits: plain store
    wr(4'd0, 8'h06);
    wr(4'd3, 8'h55);
    chk("R6 no busy both", {15'd0, busy}, 16'd0);
    rd(4'd3, v); chk("R6 stored both", {8'd0, v}, 16'h0055);
    rd(4'd2, v); chk("R6 low untouched", {8'd0, v}, 16'h00DC);
    wr(4'd0, 8'h00);
    wr(4'd3, 8'hA7);
    chk("R6 no busy none", {15'd0, busy}, 16'd0);
    rd(4'd3, v); chk("R6 stored none", {8'd0, v}, 16'h00A7);

    // R9 / R10 transmit path with expansion
    wr(4'd0, 8'h03);
    wr(4'd3, 8'hCE);
    chk("R9 no busy", {15'd0, busy}, 16'd0);
    chk("R9 tx_valid", {15'd0, tx_valid}, 16'd1);
    chk("R9 tx expand", tx_sample, 16'h03DC);
    repeat (2) @(negedge clk);
    chk("R10 held valid", {15'd0, tx_valid}, 16'd1);
    chk("R10 held data", tx_sample, 16'h03DC);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R10 drained", {15'd0, tx_valid}, 16'd0);
    rd(4'd3, v); chk("R9 hi stored", {8'd0, v}, 16'h00CE);

    // R9 transmit path raw
    wr(4'd0, 8'h01);
    wr(4'd2, 8'h34);
    wr(4'd3, 8'h12);
    chk("R9 tx raw", tx_sample, 16'h1234);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;

    // R11 receive path with compression
    wr(4'd0, 8'h05);
    rx_sample = 16'h03E8; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    rd(4'd3, v); chk("R11 rx compress", {8'd0, v}, 16'h00CE);

    // R11 receive raw
    wr(4'd0, 8'h01);
    rx_sample = 16'hBEEF; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    rd(4'd3, v); rd(4'd2, lo_v);
    chk("R11 rx raw", {v, lo_v}, 16'hBEEF);

    // R11 receive beat wins over same-cycle bus write
    rx_sample = 16'h5A5A; rx_valid = 1'b1;
    bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 8'h11;
    @(negedge clk);
    rx_valid = 1'b0; bus_wr = 1'b0;
    rd(4'd2, v); chk("R11 rx precedence", {8'd0, v}, 16'h005A);

    // R1 reset again clears state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(4'd0, v); chk("R1 cfg after reset", {8'd0, v}, 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule